// File: doc/BRIEF.md
# Reconfigurable Coprocessor Command and Stall Controller

This block sits between a scalar processor and a reconfigurable array coprocessor. The processor presents one command at a time and holds it steady until the block accepts it. A configure command makes a named configuration the active one, either at once when the configuration is held in a small set of resident slots, or after a fixed load delay when it is not. A move-to command writes one of two operand registers. A run command launches an array operation and sets how many cycles it lasts. A move-from command returns the result register.

While an operation runs, the processor is held by the `stall` output until the operation's cycle counter runs out. A command that cannot be accepted also raises `stall` for as long as it waits. The array's compute is represented by an accumulator that keeps its value from one operation to the next, so results depend on earlier operations.

Top module: `copro_ctrl`

## Requirements
- R1: After reset, `stall` and `rd_valid` are 0, `active_valid` is 0 and `rd_data` is 0.
- R2: A configure command (cmd_op = 1) whose ID is resident is accepted in the cycle it is presented, with `stall` low; from the next cycle `active_valid` is 1 and `active_cfg` equals that ID.
- R3: A configure command whose ID is not resident holds `stall` high for exactly LOAD_CYCLES (16) cycles and is accepted in the following cycle, after which the ID is active and resident.
- R4: Four configuration IDs are resident at most; a load into a full set evicts the ID whose last configure command lies furthest back.
- R5: A move-to command (cmd_op = 2) writes `cmd_data` to operand A when `cmd_sel` is 0 and to operand B when `cmd_sel` is 1.
- R6: A run command (cmd_op = 3) with cmd_cycles = N holds `stall` high in the N cycles after its acceptance, whatever is presented; N = 0 causes no stall.
- R7: A move-from command (cmd_op = 4) presented while an operation runs waits with `stall` high and is accepted in the first cycle with no operation running; `rd_valid` is 1 only in the cycle a move-from is accepted.
- R8: A configure command presented while an operation runs waits until the operation ends; `active_cfg` does not change while an operation runs.
- R9: An accepted run command with an active configuration sets the result to old_result + ((A + B) xor zero-extended active ID), modulo 2^32, and the result persists across operations.
- R10: A run command accepted while no configuration is active leaves the result unchanged and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | 0 none, 1 configure, 2 move-to, 3 run, 4 move-from |
| cmd_cfg | input | 8 | Configuration ID for configure |
| cmd_sel | input | 1 | Operand select for move-to |
| cmd_data | input | 32 | Operand value for move-to |
| cmd_cycles | input | 8 | Run length in cycles for run |
| stall | output | 1 | Processor must hold its command and wait |
| rd_valid | output | 1 | A move-from is accepted this cycle |
| rd_data | output | 32 | Result register |
| active_valid | output | 1 | A configuration is active |
| active_cfg | output | 8 | ID of the active configuration |

## Verification
Acceptance, `stall` and `rd_valid` are combinational on the presented command and the current state, so they are due in the same cycle; `active_cfg`, the result and the operation counter change one clock after acceptance, a miss is accepted 16 cycles after it is first presented, and a run stalls the N cycles after its own. The bench drives inputs on the falling edge and compares every output 1 ns later against a behavioural model that it then advances by one clock, so each value is checked in the cycle it is due. Directed checks additionally count stall cycles for misses, runs and waiting commands, and confirm which ID an eviction removed by whether a later configure stalls.

// File: rtl/copro_pkg.sv
package copro_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CFG   = 3'd1,
        OP_MTO   = 3'd2,
        OP_RUN   = 3'd3,
        OP_MFROM = 3'd4
    } cmd_op_e;
endpackage

// File: rtl/copro_cfg_cache.sv
module copro_cfg_cache #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag,
    output logic             hit,
    input  logic             touch_en,
    input  logic             install_en,
    input  logic [TAG_W-1:0] install_tag
);
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WAY_W = AGE_W;
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    typedef struct packed {
        logic [WAYS-1:0][TAG_W-1:0] tag;
        logic [WAYS-1:0]            vld;
        logic [WAYS-1:0][AGE_W-1:0] age;
    } cache_t;

    cache_t          st_q, st_d;
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] oldest_vec;
    logic [WAY_W-1:0] hit_way, vict_way, upd_way;
    logic            upd_en;
    logic [AGE_W-1:0] ref_age;

    always_comb begin
        hit_vec    = '0;
        oldest_vec = '0;
        hit_way    = '0;
        vict_way   = '0;
        for (int i = 0; i < WAYS; i++) begin
            hit_vec[i]    = st_q.vld[i] && (st_q.tag[i] == lookup_tag);
            oldest_vec[i] = (st_q.age[i] == OLDEST);
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i])    hit_way  = WAY_W'(i);
            if (oldest_vec[i]) vict_way = WAY_W'(i);
        end
        hit     = |hit_vec;
        upd_en  = install_en || (touch_en && hit);
        upd_way = install_en ? vict_way : hit_way;
        ref_age = st_q.age[upd_way];

        st_d = st_q;
        if (install_en) begin
            st_d.tag[upd_way] = install_tag;
            st_d.vld[upd_way] = 1'b1;
        end
        if (upd_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == upd_way)      st_d.age[i] = '0;
                else if (st_q.age[i] < ref_age) st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tag <= '0;
            st_q.vld <= '0;
            for (int i = 0; i < WAYS; i++) st_q.age[i] <= AGE_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    // R4: an ID is resident in at most one slot
    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R4: the recency order always names exactly one eviction victim
    a_r4_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/copro_op_timer.sv
module copro_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en)           cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R6: a running count falls by one per cycle and is never reloaded mid-run
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/copro_ctrl.sv
module copro_ctrl #(
    parameter int WAYS        = 4,
    parameter int CFG_W       = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int LOAD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [CFG_W-1:0]  cmd_cfg,
    input  logic              cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [CNT_W-1:0]  cmd_cycles,
    output logic              stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              active_valid,
    output logic [CFG_W-1:0]  active_cfg
);
    import copro_pkg::*;

    localparam int LD_W = $clog2(LOAD_CYCLES + 1);

    typedef struct packed {
        logic [LD_W-1:0]   load_cnt;
        logic [CFG_W-1:0]  load_tag;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [DATA_W-1:0] acc;
        logic              act_vld;
        logic [CFG_W-1:0]  act_cfg;
    } ctrl_t;

    ctrl_t   st_q, st_d;
    cmd_op_e op;
    logic    busy, hit, loading, accept, miss_start;
    logic    touch_en, install_en, run_go;

    always_comb begin
        op         = cmd_op_e'(cmd_op);
        loading    = (st_q.load_cnt != '0);
        if (op == OP_CFG)
            accept = cmd_valid && !busy &&
                     (loading ? (st_q.load_cnt == LD_W'(1)) : hit);
        else
            accept = cmd_valid && !busy && !loading;
        miss_start = cmd_valid && (op == OP_CFG) && !busy && !loading && !hit;
        touch_en   = accept && (op == OP_CFG) && !loading;
        install_en = accept && (op == OP_CFG) && loading;
        run_go     = accept && (op == OP_RUN) && st_q.act_vld;

        st_d = st_q;
        if (loading) st_d.load_cnt = st_q.load_cnt - 1'b1;
        if (miss_start) begin
            st_d.load_cnt = LD_W'(LOAD_CYCLES);
            st_d.load_tag = cmd_cfg;
        end
        if (accept) begin
            unique case (op)
                OP_CFG: begin
                    st_d.act_vld = 1'b1;
                    st_d.act_cfg = loading ? st_q.load_tag : cmd_cfg;
                end
                OP_MTO: begin
                    if (cmd_sel) st_d.opb = cmd_data;
                    else         st_d.opa = cmd_data;
                end
                OP_RUN: begin
                    if (st_q.act_vld)
                        st_d.acc = st_q.acc +
                                   ((st_q.opa + st_q.opb) ^ DATA_W'(st_q.act_cfg));
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    copro_cfg_cache #(.WAYS(WAYS), .TAG_W(CFG_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_tag (cmd_cfg),
        .hit        (hit),
        .touch_en   (touch_en),
        .install_en (install_en),
        .install_tag(st_q.load_tag)
    );

    copro_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (run_go),
        .load_val(cmd_cycles),
        .busy    (busy)
    );

    assign stall        = busy || (cmd_valid && !accept);
    assign rd_valid     = accept && (op == OP_MFROM);
    assign rd_data      = st_q.acc;
    assign active_valid = st_q.act_vld;
    assign active_cfg   = st_q.act_cfg;

    // R8: the active configuration is frozen while an operation runs
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(active_cfg));
    // R7: a result is never handed back while an operation runs
    a_r7_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);
    // R3: every load cycle but the last keeps the processor stalled
    a_r3_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load_cnt > LD_W'(1)) |-> stall);
    // R9: the result only changes in the cycle after a run starts
    a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_go |=> $stable(rd_data));
endmodule

// File: tb/copro_ctrl_bench.sv
module copro_ctrl_bench;
    localparam int LOAD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_cfg = 8'd0;
    logic        cmd_sel = 1'b0;
    logic [31:0] cmd_data = 32'd0;
    logic [7:0]  cmd_cycles = 8'd0;
    logic        stall, rd_valid, active_valid;
    logic [31:0] rd_data;
    logic [7:0]  active_cfg;

    always #4 clk = ~clk;

    copro_ctrl u_copro_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cfg(cmd_cfg), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
        .cmd_cycles(cmd_cycles), .stall(stall), .rd_valid(rd_valid),
        .rd_data(rd_data), .active_valid(active_valid), .active_cfg(active_cfg)
    );

    int vectors = 0;
    int miscompares = 0;
    string tag = "R1";

    // behavioural model
    logic [7:0]  resident[$];
    int          load_left = 0, op_left = 0;
    logic [7:0]  load_id = 0;
    logic [31:0] m_a = 0, m_b = 0, m_acc = 0;
    logic        m_av = 0;
    logic [7:0]  m_cfg = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic bit is_res(input logic [7:0] id);
        foreach (resident[i]) if (resident[i] == id) return 1'b1;
        return 1'b0;
    endfunction

    // one clock: compare outputs 1 ns after inputs change, then advance the model
    task automatic step(output bit acc_o);
        bit busy, loading, hit, acc, e_stall, e_rd;
        #1;
        busy    = op_left > 0;
        loading = load_left > 0;
        hit     = is_res(cmd_cfg);
        if (!cmd_valid)          acc = 1'b0;
        else if (busy)           acc = 1'b0;
        else if (cmd_op == 3'd1) acc = loading ? (load_left == 1) : hit;
        else                     acc = !loading;
        e_stall = busy || (cmd_valid && !acc);
        e_rd    = acc && cmd_op == 3'd4;
        chk(stall == e_stall, tag, "stall", 32'(stall), 32'(e_stall));
        chk(rd_valid == e_rd, tag, "rd_valid", 32'(rd_valid), 32'(e_rd));
        chk(rd_data == m_acc, tag, "rd_data", rd_data, m_acc);
        chk(active_valid == m_av, tag, "active_valid", 32'(active_valid), 32'(m_av));
        chk(active_cfg == m_cfg, tag, "active_cfg", 32'(active_cfg), 32'(m_cfg));
        // advance
        if (op_left > 0) op_left--;
        if (acc && cmd_op == 3'd1) begin
            if (loading) begin
                if (resident.size() == 4) void'(resident.pop_front());
                resident.push_back(load_id);
                m_cfg = load_id;
            end else begin
                foreach (resident[i]) if (resident[i] == cmd_cfg) begin
                    resident.delete(i);
                    break;
                end
                resident.push_back(cmd_cfg);
                m_cfg = cmd_cfg;
            end
            m_av = 1'b1;
        end
        if (loading) load_left--;
        else if (cmd_valid && cmd_op == 3'd1 && !busy && !hit) begin
            load_left = LOAD;
            load_id   = cmd_cfg;
        end
        if (acc && cmd_op == 3'd2) begin
            if (cmd_sel) m_b = cmd_data; else m_a = cmd_data;
        end
        if (acc && cmd_op == 3'd3 && m_av) begin
            m_acc   = m_acc + ((m_a + m_b) ^ {24'd0, m_cfg});
            op_left = cmd_cycles;
        end
        acc_o = acc;
        @(negedge clk);
    endtask

    // present a command and hold it until accepted; returns the stall cycles seen
    task automatic issue(input logic [2:0] op, input logic [7:0] cfg,
                         input logic sel, input logic [31:0] data,
                         input logic [7:0] cyc, output int stalls);
        bit acc;
        stalls = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_cfg = cfg;
        cmd_sel = sel; cmd_data = data; cmd_cycles = cyc;
        for (int k = 0; k < 1000; k++) begin
            step(acc);
            if (acc) break;
            stalls++;
        end
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int k = 0; k < n; k++) step(acc);
    endtask

    task automatic cfg(input logic [7:0] id, input int exp_st, input string req);
        int s;
        tag = req;
        issue(3'd1, id, 1'b0, 32'd0, 8'd0, s);
        chk(s == exp_st, req, "configure stall cycles", 32'(s), 32'(exp_st));
    endtask

    initial begin
        int s;
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked by the comparisons of the first steps
        tag = "R1";
        idle(2);
        // R10: run without an active configuration is ignored
        tag = "R10";
        issue(3'd2, 8'd0, 1'b0, 32'd9, 8'd0, s);
        issue(3'd3, 8'd0, 1'b0, 32'd0, 8'd5, s);
        chk(s == 0, "R10", "run stall", 32'(s), 32'd0);
        idle(1);
        chk(stall == 1'b0 && rd_data == 32'd0, "R10", "no effect", rd_data, 32'd0);
        // R3: first configure misses
        cfg(8'h11, LOAD, "R3");
        chk(active_cfg == 8'h11, "R3", "active after load", 32'(active_cfg), 32'h11);
        // R2: second configure hits
        cfg(8'h11, 0, "R2");
        // R5, R9, R7: operands, run, read back during run
        tag = "R5";
        issue(3'd2, 8'd0, 1'b0, 32'd5, 8'd0, s);
        issue(3'd2, 8'd0, 1'b1, 32'd7, 8'd0, s);
        tag = "R6";
        issue(3'd3, 8'd0, 1'b0, 32'd0, 8'd4, s);
        tag = "R7";
        issue(3'd4, 8'd0, 1'b0, 32'd0, 8'd0, s);
        chk(s == 4, "R7", "move-from wait cycles", 32'(s), 32'd4);
        chk(rd_data == 32'h1d, "R9", "first result", rd_data, 32'h1d);
        tag = "R9";
        issue(3'd3, 8'd0, 1'b0, 32'd0, 8'd1, s);
        issue(3'd4, 8'd0, 1'b0, 32'd0, 8'd0, s);
        chk(s == 1, "R6", "one-cycle run", 32'(s), 32'd1);
        chk(rd_data == 32'h3a, "R9", "accumulated result", rd_data, 32'h3a);
        // R6: zero-length run
        tag = "R6";
        issue(3'd3, 8'd0, 1'b0, 32'd0, 8'd0, s);
        issue(3'd4, 8'd0, 1'b0, 32'd0, 8'd0, s);
        chk(s == 0, "R6", "zero-length run stall", 32'(s), 32'd0);
        // R4: fill, refresh 0x11, evict 0x22
        cfg(8'h22, LOAD, "R4");
        cfg(8'h33, LOAD, "R4");
        cfg(8'h44, LOAD, "R4");
        cfg(8'h11, 0, "R4");
        cfg(8'h55, LOAD, "R4");
        cfg(8'h11, 0, "R4");
        cfg(8'h22, LOAD, "R4");
        cfg(8'h44, 0, "R4");
        cfg(8'h33, LOAD, "R4");
        // R8: configure during a run waits, even on a hit
        tag = "R8";
        issue(3'd3, 8'd0, 1'b0, 32'd0, 8'd6, s);
        cfg(8'h44, 6, "R8");
        chk(active_cfg == 8'h44, "R8", "active after wait", 32'(active_cfg), 32'h44);
        // mixed traffic against the model
        tag = "R4";
        lfsr = 32'h1ace;
        for (int n = 0; n < 300; n++) begin
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            issue(3'((lfsr >> 16) % 4 + 1), 8'((lfsr >> 8) % 6 + 1),
                  lfsr[20], lfsr, 8'((lfsr >> 24) % 8), s);
            if (lfsr[27]) idle(int'(lfsr[29:28]));
        end
        idle(12);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog expired during %s", tag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule